// File: doc/BRIEF.md
# Composite-Sync 15 kHz Video Timing Generator

This block produces the line and frame timing for progressive-scan RGB video at the 15 kHz PAL line rate, using a fast system clock. A horizontal counter divides the clock into lines of a fixed number of cycles; at 168 MHz the default of 10752 cycles gives a 64 µs line. A line counter groups 312 such lines into a frame. Every line falls into one of three classes: vertical-sync, blanked porch, or display.

Horizontal and vertical synchronisation share a single active-low, registered output. Porch and display lines carry a short low pulse at the start of the line. Vertical-sync lines carry a long pulse that covers almost the whole line, which is how the display finds the top of the frame.

A downstream pixel streamer uses four outputs from the block:
- a start-of-line strobe;
- a start-of-frame strobe;
- the current line index and its 2-bit class;
- a display-enable window that marks where pixels are fetched on display lines.

Five settings live in a small register bank: the short and long pulse widths, and the counts of top-porch, vertical-sync and bottom-porch lines. They can only be written while the generator is stopped. Enlarging a porch count adds a black border. With the defaults, 271 display lines remain.

Top module: `pal_csync_timer`

## Requirements
- R1: Every line lasts exactly CLK_PER_LINE clock cycles. `sol` is high for one cycle, in the first cycle of each line (horizontal position 0).
- R2: `line_idx` counts 0 to LINES_PER_FRAME-1 and then wraps to 0. `sof` is high only in the first cycle of line 0.
- R3: `line_type` gives the class of `line_idx`, with 2'b10 for vertical-sync, 2'b01 for porch and 2'b00 for display. Lines are classified as follows (nv, nt and nb are the vsync, top-porch and bottom-porch counts):
  - lines 0..nv-1 are vertical-sync;
  - the next nt lines are porch;
  - the last nb lines of the frame are porch;
  - all remaining lines are display.
- R4: On porch and display lines, `csync_n` is low for exactly the first short-width cycles of the line (positions 0..w-1) and high for the rest. A width of 0 gives no pulse.
- R5: On vertical-sync lines, `csync_n` is low for the first long-width cycles. A width of CLK_PER_LINE or more holds it low for the whole line.
- R6: `de` is high only on display lines, at horizontal positions ACT_START to ACT_START+ACT_LEN-1.
- R7: After `run` is sampled high from the stopped state, the next cycle is position 0 of line 0: `sol` and `sof` are high and `csync_n` is low if the pulse width is nonzero.
- R8: While stopped, in the cycle after `run` is sampled low and until it restarts:
  - `csync_n` is high;
  - `sol`, `sof` and `de` are low;
  - `line_idx` is 0.
- R9: A write with `cfg_we` high is accepted only when `run` is low and the generator is stopped. The address map is: 0 short width, 1 long width, 2 top-porch count, 3 vsync count, 4 bottom-porch count. A write made while running has no effect on the timing.
- R10: After reset, the settings equal the DEF_* parameters. With the default parameters this gives 271 display lines in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to generate timing; low stops and clears the counters |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 3 | Settings register select |
| cfg_wdata | input | 16 | Settings write value |
| csync_n | output | 1 | Registered active-low composite sync |
| line_type | output | 2 | Class of the current line |
| line_idx | output | LW | Current line within the frame |
| sol | output | 1 | Start-of-line strobe |
| sof | output | 1 | Start-of-frame strobe |
| de | output | 1 | Pixel display-enable window |

## Verification
Two events can fall in the same cycle at a frame boundary.

The first pair is the end of a vertical-sync line whose long pulse fills the whole line and the start of the next line. To provoke it, the long width is set to the full line length, so the pulse of one line runs straight into the pulse of the next. The bench then judges that `csync_n` stays low across the boundary while `sol` still rises.

The second pair is the start-of-frame strobe and a settings write. The bench issues write attempts exactly at the cycle that wraps into line 0, and also at random points while running. Every following line must keep the old pulse widths and line classes, which the bench model predicts.

// File: rtl/pal_csync_pkg.sv
package pal_csync_pkg;

  typedef enum logic [1:0] {
    LT_DISP  = 2'b00,
    LT_PORCH = 2'b01,
    LT_VSYNC = 2'b10
  } line_kind_e;

  typedef enum logic [2:0] {
    CA_SHORT = 3'd0,
    CA_LONG  = 3'd1,
    CA_TOP   = 3'd2,
    CA_VSN   = 3'd3,
    CA_BOT   = 3'd4
  } cfg_addr_e;

  localparam int unsigned CFG_DW = 16;

  // Class of a line: vsync lines first, then top porch, display, bottom porch.
  function automatic line_kind_e classify(input int unsigned line,
                                          input int unsigned n_vs,
                                          input int unsigned n_top,
                                          input int unsigned n_bot,
                                          input int unsigned n_lines);
    if (line < n_vs)             return LT_VSYNC;
    if (line < n_vs + n_top)     return LT_PORCH;
    if (line + n_bot >= n_lines) return LT_PORCH;
    return LT_DISP;
  endfunction

  // Sync pulse is low while the position is below the width.
  function automatic logic pulse_low(input int unsigned hpos,
                                     input int unsigned width);
    return (hpos < width);
  endfunction

  // Half-open window test [start, start+len).
  function automatic logic in_window(input int unsigned hpos,
                                     input int unsigned start,
                                     input int unsigned len);
    return (hpos >= start) && (hpos < start + len);
  endfunction

endpackage

// File: rtl/pal_cfg_regs.sv
module pal_cfg_regs
  import pal_csync_pkg::*;
#(
  parameter int unsigned WW        = 14,
  parameter int unsigned CW        = 9,
  parameter int unsigned DEF_SHORT = 790,
  parameter int unsigned DEF_LONG  = 9962,
  parameter int unsigned DEF_TOP   = 19,
  parameter int unsigned DEF_VSN   = 3,
  parameter int unsigned DEF_BOT   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [2:0]        addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [WW-1:0]     short_w,
  output logic [WW-1:0]     long_w,
  output logic [CW-1:0]     n_top,
  output logic [CW-1:0]     n_vsn,
  output logic [CW-1:0]     n_bot
);

  logic cfg_unused;
  assign cfg_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_w <= WW'(DEF_SHORT);
      long_w  <= WW'(DEF_LONG);
      n_top   <= CW'(DEF_TOP);
      n_vsn   <= CW'(DEF_VSN);
      n_bot   <= CW'(DEF_BOT);
    end else if (wr_accept) begin
      case (addr)
        CA_SHORT: short_w <= wdata[WW-1:0];
        CA_LONG:  long_w  <= wdata[WW-1:0];
        CA_TOP:   n_top   <= wdata[CW-1:0];
        CA_VSN:   n_vsn   <= wdata[CW-1:0];
        CA_BOT:   n_bot   <= wdata[CW-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pal_hcount.sv
module pal_hcount #(
  parameter int unsigned PERIOD = 10752,
  parameter int unsigned HW     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [HW-1:0] hpos,
  output logic [HW-1:0] hpos_nxt,
  output logic          line_end
);

  localparam logic [HW-1:0] LAST = HW'(PERIOD - 1);

  assign line_end = adv && (hpos == LAST);

  always_comb begin
    if (!adv)          hpos_nxt = '0;
    else if (line_end) hpos_nxt = '0;
    else               hpos_nxt = hpos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpos <= '0;
    else        hpos <= hpos_nxt;
  end

endmodule

// File: rtl/pal_vcount.sv
module pal_vcount #(
  parameter int unsigned LINES = 312,
  parameter int unsigned LW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          line_end,
  output logic [LW-1:0] line,
  output logic [LW-1:0] line_nxt,
  output logic          frame_end
);

  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  assign frame_end = line_end && (line == LAST);

  always_comb begin
    if (!adv)           line_nxt = '0;
    else if (frame_end) line_nxt = '0;
    else if (line_end)  line_nxt = line + 1'b1;
    else                line_nxt = line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '0;
    else        line <= line_nxt;
  end

endmodule

// File: rtl/pal_csync_timer.sv
module pal_csync_timer
  import pal_csync_pkg::*;
#(
  parameter int unsigned CLK_PER_LINE    = 10752,
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned ACT_START       = 1764,
  parameter int unsigned ACT_LEN         = 8736,
  parameter int unsigned DEF_SHORT       = 790,
  parameter int unsigned DEF_LONG        = 9962,
  parameter int unsigned DEF_TOP         = 19,
  parameter int unsigned DEF_VSN         = 3,
  parameter int unsigned DEF_BOT         = 19,
  localparam int unsigned LW = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              csync_n,
  output logic [1:0]        line_type,
  output logic [LW-1:0]     line_idx,
  output logic              sol,
  output logic              sof,
  output logic              de
);

  localparam int unsigned HW = $clog2(CLK_PER_LINE);
  localparam int unsigned WW = $clog2(CLK_PER_LINE + 1);
  localparam int unsigned CW = $clog2(LINES_PER_FRAME + 1);

  // Named internal events, also watched by the bound checker.
  logic          act;
  logic          adv;
  logic          wr_accept;
  logic          line_end;
  logic          frame_end;
  logic [HW-1:0] hpos, hpos_nxt;
  logic [LW-1:0] line, line_nxt;
  logic [WW-1:0] short_w, long_w;
  logic [CW-1:0] n_top, n_vsn, n_bot;
  line_kind_e    kind_now, kind_nxt;
  logic [WW-1:0] width_nxt;
  logic          csync_q;

  assign adv       = run && act;
  assign wr_accept = cfg_we && !run && !act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= 1'b0;
    else        act <= run;
  end

  pal_cfg_regs #(
    .WW(WW), .CW(CW),
    .DEF_SHORT(DEF_SHORT), .DEF_LONG(DEF_LONG),
    .DEF_TOP(DEF_TOP), .DEF_VSN(DEF_VSN), .DEF_BOT(DEF_BOT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept),
    .addr(cfg_addr), .wdata(cfg_wdata),
    .short_w(short_w), .long_w(long_w),
    .n_top(n_top), .n_vsn(n_vsn), .n_bot(n_bot)
  );

  pal_hcount #(.PERIOD(CLK_PER_LINE), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .hpos(hpos), .hpos_nxt(hpos_nxt), .line_end(line_end)
  );

  pal_vcount #(.LINES(LINES_PER_FRAME), .LW(LW)) u_v (
    .clk(clk), .rst_n(rst_n), .adv(adv), .line_end(line_end),
    .line(line), .line_nxt(line_nxt), .frame_end(frame_end)
  );

  always_comb begin
    kind_now = classify(32'(line), 32'(n_vsn), 32'(n_top), 32'(n_bot),
                        LINES_PER_FRAME);
    kind_nxt = classify(32'(line_nxt), 32'(n_vsn), 32'(n_top), 32'(n_bot),
                        LINES_PER_FRAME);
    width_nxt = (kind_nxt == LT_VSYNC) ? long_w : short_w;
  end

  // Sync is computed from the next counter state so the flop output lines
  // up with the counters without a combinational path to the pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csync_q <= 1'b1;
    else        csync_q <= !(run && pulse_low(32'(hpos_nxt), 32'(width_nxt)));
  end

  assign csync_n   = csync_q;
  assign line_type = kind_now;
  assign line_idx  = line;
  assign sol       = act && (hpos == '0);
  assign sof       = sol && (line == '0);
  assign de        = act && (kind_now == LT_DISP) &&
                     in_window(32'(hpos), ACT_START, ACT_LEN);

endmodule

// File: rtl/pal_csync_checker.sv
module pal_csync_checker #(
  parameter int unsigned PERIOD = 10752,
  parameter int unsigned LINES  = 312,
  parameter int unsigned LW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act,
  input logic          csync_n,
  input logic [1:0]    line_type,
  input logic [LW-1:0] line_idx,
  input logic          sol,
  input logic          sof,
  input logic          de,
  input logic          line_end
);

  int unsigned since_sol;
  logic        seen_sol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_sol <= 0;
      seen_sol  <= 1'b0;
    end else if (!act) begin
      since_sol <= 0;
      seen_sol  <= 1'b0;
    end else if (sol) begin
      since_sol <= 0;
      seen_sol  <= 1'b1;
    end else begin
      since_sol <= since_sol + 1;
    end
  end

  assert_line_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && sol && seen_sol) |-> (since_sol == PERIOD - 1));

  assert_sol_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> !sol);

  assert_line_end_then_sol_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> sol);

  assert_sof_on_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (sol && line_idx == '0));

  assert_line_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(line_idx) < LINES);

  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_type != 2'b11);

  assert_sync_falls_at_sol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csync_n) |-> sol);

  assert_de_display_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (line_type == 2'b00));

  assert_start_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> (sol && sof));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (csync_n && !sol && !sof && !de && line_idx == '0));

endmodule

bind pal_csync_timer pal_csync_checker #(
  .PERIOD(CLK_PER_LINE), .LINES(LINES_PER_FRAME), .LW(LW)
) u_check (
  .clk(clk), .rst_n(rst_n), .act(act), .csync_n(csync_n),
  .line_type(line_type), .line_idx(line_idx), .sol(sol), .sof(sof),
  .de(de), .line_end(line_end)
);

// File: tb/test_pal_csync_timer.sv
module test_pal_csync_timer;

  localparam int LINE  = 64;
  localparam int LINES = 40;
  localparam int AST   = 10;
  localparam int ALEN  = 48;
  localparam int D_SH  = 5;
  localparam int D_LG  = 56;
  localparam int D_TOP = 4;
  localparam int D_VS  = 3;
  localparam int D_BOT = 5;
  localparam int LWT   = $clog2(LINES);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           run = 1'b0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_addr = '0;
  logic [15:0]    cfg_wdata = '0;
  logic           csync_n, sol, sof, de;
  logic [1:0]     line_type;
  logic [LWT-1:0] line_idx;

  pal_csync_timer #(
    .CLK_PER_LINE(LINE), .LINES_PER_FRAME(LINES),
    .ACT_START(AST), .ACT_LEN(ALEN),
    .DEF_SHORT(D_SH), .DEF_LONG(D_LG),
    .DEF_TOP(D_TOP), .DEF_VSN(D_VS), .DEF_BOT(D_BOT)
  ) i_pal_csync_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .csync_n(csync_n),
    .line_type(line_type), .line_idx(line_idx), .sol(sol), .sof(sof), .de(de)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int k = -1;
  int m_sh = D_SH, m_lg = D_LG, m_top = D_TOP, m_vs = D_VS, m_bot = D_BOT;
  int disp_count = 0;
  string cs_tag = "";

  function automatic int exp_kind(input int l);
    int first_disp, end_disp;
    first_disp = m_vs + m_top;
    end_disp   = LINES - m_bot;
    if (l < m_vs) return 2;
    if (l < first_disp || l >= end_disp) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act_v, input int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", tag, k, act_v, exp_v);
    end
  endtask

  task automatic check_now();
    int h, l, kind, w;
    int e_cs, e_sol, e_sof, e_de;
    if (k < 0) begin h = 0; l = 0; end
    else begin h = k % LINE; l = (k / LINE) % LINES; end
    kind = exp_kind(l);
    if (k < 0) begin
      e_cs = 1; e_sol = 0; e_sof = 0; e_de = 0;
      chk("R8 idle csync_n", int'(csync_n), e_cs);
      chk("R8 idle sol", int'(sol), e_sol);
      chk("R8 idle sof", int'(sof), e_sof);
      chk("R8 idle de", int'(de), e_de);
      chk("R8 idle line_idx", int'(line_idx), 0);
    end else begin
      w = (kind == 2) ? m_lg : m_sh;
      e_cs  = (h < w) ? 0 : 1;
      e_sol = (h == 0) ? 1 : 0;
      e_sof = (h == 0 && l == 0) ? 1 : 0;
      e_de  = (kind == 0 && h >= AST && h < AST + ALEN) ? 1 : 0;
      if (cs_tag != "")   chk({cs_tag, " csync_n"}, int'(csync_n), e_cs);
      else if (kind == 2) chk("R5 long csync_n", int'(csync_n), e_cs);
      else                chk("R4 short csync_n", int'(csync_n), e_cs);
      if (k == 0) begin
        chk("R7 start sol", int'(sol), 1);
        chk("R7 start sof", int'(sof), 1);
      end
      chk("R1 sol", int'(sol), e_sol);
      chk("R2 sof", int'(sof), e_sof);
      chk("R2 line_idx", int'(line_idx), l);
      chk("R6 de", int'(de), e_de);
      if (sol && line_type == 2'b00) disp_count++;
    end
    chk("R3 line_type", int'(line_type), kind);
  endtask

  task automatic step(input logic r, input logic we, input int a, input int d);
    @(negedge clk);
    check_now();
    run = r; cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    if (we && !r && k < 0) begin
      case (a)
        0: m_sh  = d % 128;
        1: m_lg  = d % 128;
        2: m_top = d % 64;
        3: m_vs  = d % 64;
        4: m_bot = d % 64;
        default: ;
      endcase
    end
    k = r ? ((k < 0) ? 0 : k + 1) : -1;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 0);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    tests++;
    if (csync_n !== 1'b1 || sol !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset state actual=%0d%0d expected=10", csync_n, sol);
    end
    rst_n = 1'b1;
    idle_n(4);

    // R10: defaults, count display lines in one frame
    disp_count = 0;
    run_n(LINES * LINE + 1);
    chk("R10 display lines per frame", disp_count, LINES - D_VS - D_TOP - D_BOT);

    // R9: write attempts while running, including at the wrap into line 0
    cs_tag = "R9";
    run_n(LINES * LINE - 2);
    step(1'b1, 1'b1, 0, 20);
    step(1'b1, 1'b1, 3, 9);
    run_n(3 * LINE);
    step(1'b1, 1'b1, 1, 2);
    run_n(2 * LINE);
    cs_tag = "";

    // R8: stop mid-line and stay idle, then R7 restart from line 0
    idle_n(10);
    run_n(3 * LINE);

    // Corner: short width 0, long width covering the whole line (R4, R5)
    idle_n(2);
    step(1'b0, 1'b1, 0, 0);
    step(1'b0, 1'b1, 1, LINE);
    run_n(LINES * LINE + 5);
    idle_n(2);

    // Corner: long width beyond the line, zero porches
    step(1'b0, 1'b1, 1, LINE + 30);
    step(1'b0, 1'b1, 0, 1);
    step(1'b0, 1'b1, 2, 0);
    step(1'b0, 1'b1, 4, 0);
    run_n(LINES * LINE + 3);
    idle_n(2);

    // Constrained random configurations
    for (int it = 0; it < 8; it++) begin
      step(1'b0, 1'b1, 0, int'($urandom_range(1, 12)));
      step(1'b0, 1'b1, 1, int'($urandom_range(30, 70)));
      step(1'b0, 1'b1, 2, int'($urandom_range(0, 6)));
      step(1'b0, 1'b1, 3, int'($urandom_range(1, 4)));
      step(1'b0, 1'b1, 4, int'($urandom_range(0, 6)));
      for (int j = 0; j < 2 * LINES * LINE; j++)
        step(1'b1, ($urandom_range(0, 499) == 0) ? 1'b1 : 1'b0,
             int'($urandom_range(0, 4)), int'($urandom_range(0, 60)));
      idle_n(int'($urandom_range(1, 5)));
    end

    summary();
    $finish;
  end

endmodule